// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block sits beside the exception logic of a small processor core and decides, when asked, whether the interrupt at the pending level is accepted. If it is accepted, the block produces every state change for entry in one registered step. These are the new program counter, the new status word, and write strobes with data for the saved-PC, saved-status, double-exception PC and exception-cause registers. A one-cycle pulse marks the entry.

Levels above 1 are high-priority entries. Each such level has its own saved-PC and saved-status slot and its own vector. Level 1 is not given a vector of its own. It is turned into an ordinary exception with a fixed cause code, and the status word selects the handler: the user vector, the kernel vector, or the double-exception vector when an exception is already in progress. Vector targets can be moved at run time through a vector-base input.

Top module: `irq_dispatch`

## Requirements
- R1: A dispatch happens only in the cycle after `check_i` was high with `pend_level_i` strictly greater than the current level `ps_i[3:0]`, `pend_level_i` no larger than `NUM_LEVELS`, and a nonzero AND of the pending level's mask group (`lvl_mask_i` bits `[k*NIRQ +: NIRQ]` for level k) with `intset_i` and `inten_i`. Otherwise `taken_o` and every write strobe stay low.
- R2: All outputs are registered. `taken_o` is high for exactly the one cycle that follows the accepting edge, and low after reset.
- R3: For a level L > 1, the unit writes `pc_i` to saved-PC slot L-1 (`epc_sel_o`) and `ps_i` to saved-status slot L-2 (`eps_sel_o`). The new status is `ps_i` with bits [3:0] set to L and the exception-mode bit (bit 4) set. The new PC is the vector for level L.
- R4: A level-1 entry writes the cause code `L1_CAUSE` (default 4) to the exception-cause register. Other entries do not write that register.
- R5: A level-1 entry with status bit 4 already set goes to the double-exception vector. The PC goes to the double-exception PC register when `HAS_DEPC` is 1, and to saved-PC slot 0 when it is 0.
- R6: A level-1 entry with status bit 4 clear saves the PC in saved-PC slot 0. It goes to the user vector when status bit 5 is set and to the kernel vector when bit 5 is clear.
- R7: A level-1 entry writes back `ps_i` with only bit 4 forced to 1. Bits [3:0] and bit 5 are left as they were.
- R8: With `RELOC_EN` = 1, the target is the fixed vector minus `DEF_VECBASE` plus `vecbase_i`. With `RELOC_EN` = 0, the fixed vector is used unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| check_i | input | 1 | Evaluate the pending interrupt this cycle |
| pend_level_i | input | LW | Pending interrupt level, 0 = none |
| lvl_mask_i | input | (NUM_LEVELS+1)*NIRQ | Per-level interrupt membership masks |
| intset_i | input | NIRQ | Interrupt set (pending) register |
| inten_i | input | NIRQ | Interrupt enable register |
| ps_i | input | XLEN | Status word: [3:0] level, 4 exception mode, 5 user mode |
| pc_i | input | XLEN | Current program counter |
| vecbase_i | input | XLEN | Vector-base register |
| taken_o | output | 1 | Dispatch pulse |
| pc_o | output | XLEN | Next program counter |
| ps_we_o | output | 1 | Status write strobe |
| ps_o | output | XLEN | New status word |
| epc_we_o | output | 1 | Saved-PC write strobe |
| epc_sel_o | output | LW | Saved-PC slot (level-1) |
| epc_data_o | output | XLEN | Saved-PC data |
| eps_we_o | output | 1 | Saved-status write strobe |
| eps_sel_o | output | LW | Saved-status slot (level-2) |
| eps_data_o | output | XLEN | Saved-status data |
| depc_we_o | output | 1 | Double-exception PC write strobe |
| depc_data_o | output | XLEN | Double-exception PC data |
| cause_we_o | output | 1 | Exception-cause write strobe |
| cause_o | output | 8 | Exception-cause value |

## Verification
The assertions assume that `ps_i[3:0]` stays within the width of `pend_level_i` plus one bit. They also assume that inputs are steady at the clock edge on which `check_i` is sampled. The bench drives every input on the falling edge and raises `check_i` for single cycles, so each acceptance is tied to one known edge. The status words it applies keep the level field between 0 and 7. Pending levels above `NUM_LEVELS` are driven on purpose, with the set and enable registers all ones, to show that the range limit holds by itself.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int XLEN       = 32,
  parameter int NIRQ       = 8,
  parameter int NUM_LEVELS = 6,
  parameter int LW         = $clog2(NUM_LEVELS + 2),
  parameter logic [NUM_LEVELS:0][XLEN-1:0] LVL_VEC = {
    32'h280, 32'h240, 32'h200, 32'h1C0, 32'h180, 32'h140, 32'h100},
  parameter logic [XLEN-1:0] KERN_VEC    = 32'h300,
  parameter logic [XLEN-1:0] USER_VEC    = 32'h340,
  parameter logic [XLEN-1:0] DBL_VEC     = 32'h3C0,
  parameter logic [XLEN-1:0] DEF_VECBASE = 32'h100,
  parameter bit              RELOC_EN    = 1'b1,
  parameter bit              HAS_DEPC    = 1'b1,
  parameter logic [7:0]      L1_CAUSE    = 8'd4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         check_i,
  input  logic [LW-1:0]                pend_level_i,
  input  logic [(NUM_LEVELS+1)*NIRQ-1:0] lvl_mask_i,
  input  logic [NIRQ-1:0]              intset_i,
  input  logic [NIRQ-1:0]              inten_i,
  input  logic [XLEN-1:0]              ps_i,
  input  logic [XLEN-1:0]              pc_i,
  input  logic [XLEN-1:0]              vecbase_i,
  output logic                         taken_o,
  output logic [XLEN-1:0]              pc_o,
  output logic                         ps_we_o,
  output logic [XLEN-1:0]              ps_o,
  output logic                         epc_we_o,
  output logic [LW-1:0]                epc_sel_o,
  output logic [XLEN-1:0]              epc_data_o,
  output logic                         eps_we_o,
  output logic [LW-1:0]                eps_sel_o,
  output logic [XLEN-1:0]              eps_data_o,
  output logic                         depc_we_o,
  output logic [XLEN-1:0]              depc_data_o,
  output logic                         cause_we_o,
  output logic [7:0]                   cause_o
);
  localparam int LVLB = 4;
  localparam int EXCM = 4;
  localparam int UM   = 5;

  logic [NIRQ-1:0] lvl_mask;
  logic [XLEN-1:0] lvl_vec;
  logic [LVLB-1:0] pend_x;
  logic            in_range, above, live, go, hi;
  logic [XLEN-1:0] l1_vec, raw_vec, tgt;

  always_comb begin
    lvl_mask = '0;
    lvl_vec  = '0;
    for (int k = 0; k <= NUM_LEVELS; k++) begin
      if (int'(pend_level_i) == k) begin
        lvl_mask = lvl_mask_i[k*NIRQ +: NIRQ];
        lvl_vec  = LVL_VEC[k];
      end
    end
  end

  assign pend_x   = LVLB'(pend_level_i);
  assign in_range = int'(pend_level_i) <= NUM_LEVELS;
  assign above    = pend_x > ps_i[LVLB-1:0];
  assign live     = |(lvl_mask & intset_i & inten_i);
  assign go       = check_i && in_range && above && live;
  assign hi       = pend_level_i > LW'(1);

  assign l1_vec  = ps_i[EXCM] ? DBL_VEC : (ps_i[UM] ? USER_VEC : KERN_VEC);
  assign raw_vec = hi ? lvl_vec : l1_vec;
  assign tgt     = RELOC_EN ? (raw_vec - DEF_VECBASE + vecbase_i) : raw_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      pc_o        <= '0;
      ps_we_o     <= 1'b0;
      ps_o        <= '0;
      epc_we_o    <= 1'b0;
      epc_sel_o   <= '0;
      epc_data_o  <= '0;
      eps_we_o    <= 1'b0;
      eps_sel_o   <= '0;
      eps_data_o  <= '0;
      depc_we_o   <= 1'b0;
      depc_data_o <= '0;
      cause_we_o  <= 1'b0;
      cause_o     <= '0;
    end else begin
      taken_o    <= go;
      ps_we_o    <= go;
      epc_we_o   <= 1'b0;
      eps_we_o   <= 1'b0;
      depc_we_o  <= 1'b0;
      cause_we_o <= 1'b0;
      if (go) begin
        pc_o <= tgt;
        if (hi) begin
          epc_we_o   <= 1'b1;
          epc_sel_o  <= pend_level_i - LW'(1);
          epc_data_o <= pc_i;
          eps_we_o   <= 1'b1;
          eps_sel_o  <= pend_level_i - LW'(2);
          eps_data_o <= ps_i;
          ps_o       <= {ps_i[XLEN-1:EXCM+1], 1'b1, pend_x};
        end else begin
          cause_we_o <= 1'b1;
          cause_o    <= L1_CAUSE;
          ps_o       <= ps_i | (XLEN'(1) << EXCM);
          if (ps_i[EXCM] && HAS_DEPC) begin
            depc_we_o   <= 1'b1;
            depc_data_o <= pc_i;
          end else begin
            epc_we_o   <= 1'b1;
            epc_sel_o  <= '0;
            epc_data_o <= pc_i;
          end
        end
      end
    end
  end

  AST_NO_CHECK_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !check_i |=> !taken_o); // R1
  AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (check_i && (LVLB'(pend_level_i) <= ps_i[LVLB-1:0])) |=> !taken_o); // R1
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> !(ps_we_o || epc_we_o || eps_we_o || depc_we_o || cause_we_o)); // R2
  AST_HI_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    eps_we_o |-> (ps_o[EXCM] && ps_o[LVLB-1:0] == LVLB'(eps_sel_o) + LVLB'(2))); // R3
  AST_HI_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    eps_we_o |-> (epc_we_o && epc_sel_o == eps_sel_o + LW'(1) && !cause_we_o)); // R3
  AST_ONE_PC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $countones({epc_we_o, depc_we_o}) == 1); // R5
  AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ps_o[EXCM]); // R7
  AST_L1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we_o |-> (cause_o == L1_CAUSE && !eps_we_o)); // R4
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int NIRQ = 8;
  localparam int NL   = 6;
  localparam int LW   = $clog2(NL + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic check;
  logic [LW-1:0] pend;
  logic [(NL+1)*NIRQ-1:0] masks;
  logic [NIRQ-1:0] iset, ien;
  logic [XLEN-1:0] ps, pc, vb;

  logic taken_a, ps_we_a, epc_we_a, eps_we_a, depc_we_a, cause_we_a;
  logic [XLEN-1:0] pc_a, ps_a, epcd_a, epsd_a, depcd_a;
  logic [LW-1:0] epcs_a, epss_a;
  logic [7:0] cause_a;
  logic taken_b, ps_we_b, epc_we_b, eps_we_b, depc_we_b, cause_we_b;
  logic [XLEN-1:0] pc_b, ps_b, epcd_b, epsd_b, depcd_b;
  logic [LW-1:0] epcs_b, epss_b;
  logic [7:0] cause_b;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch #(.NUM_LEVELS(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .check_i(check), .pend_level_i(pend),
    .lvl_mask_i(masks), .intset_i(iset), .inten_i(ien), .ps_i(ps),
    .pc_i(pc), .vecbase_i(vb), .taken_o(taken_a), .pc_o(pc_a),
    .ps_we_o(ps_we_a), .ps_o(ps_a), .epc_we_o(epc_we_a), .epc_sel_o(epcs_a),
    .epc_data_o(epcd_a), .eps_we_o(eps_we_a), .eps_sel_o(epss_a),
    .eps_data_o(epsd_a), .depc_we_o(depc_we_a), .depc_data_o(depcd_a),
    .cause_we_o(cause_we_a), .cause_o(cause_a));

  irq_dispatch #(.NUM_LEVELS(NL), .RELOC_EN(1'b0), .HAS_DEPC(1'b0)) u_dut_plain (
    .clk(clk), .rst_n(rst_n), .check_i(check), .pend_level_i(pend),
    .lvl_mask_i(masks), .intset_i(iset), .inten_i(ien), .ps_i(ps),
    .pc_i(pc), .vecbase_i(vb), .taken_o(taken_b), .pc_o(pc_b),
    .ps_we_o(ps_we_b), .ps_o(ps_b), .epc_we_o(epc_we_b), .epc_sel_o(epcs_b),
    .epc_data_o(epcd_b), .eps_we_o(eps_we_b), .eps_sel_o(epss_b),
    .eps_data_o(epsd_b), .depc_we_o(depc_we_b), .depc_data_o(depcd_b),
    .cause_we_o(cause_we_b), .cause_o(cause_b));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic dispatch(input int lvl, input logic [31:0] st, input logic [31:0] cur_pc,
                          input logic [31:0] base, input logic [7:0] s, input logic [7:0] e);
    @(negedge clk);
    pend = LW'(lvl); ps = st; pc = cur_pc; vb = base; iset = s; ien = e; check = 1'b1;
    @(negedge clk);
    check = 1'b0;
  endtask

  // Expected values follow R1 and R3..R8; reloc/depc select the variant.
  task automatic verify(input string tag, input bit b, input int lvl, input logic [31:0] st,
                        input logic [31:0] cur_pc, input logic [31:0] base,
                        input logic [7:0] s, input logic [7:0] e);
    logic [31:0] vec, epc_pc, nps;
    bit take, ewe, swe, dwe, cwe;
    int esel;
    logic t, pwe, ew, sw, dw, cw;
    logic [31:0] po, so, ed, sd, dd;
    logic [LW-1:0] es, ss;
    logic [7:0] ca;
    logic [7:0] m;
    m = (lvl <= NL) ? (8'h1 << lvl) : 8'h0;
    take = (lvl > int'(st[3:0])) && (lvl <= NL) && ((m & s & e) != 0);
    ewe = 0; swe = 0; dwe = 0; cwe = 0; esel = 0;
    if (lvl > 1) begin
      ewe = 1; swe = 1; esel = lvl - 1;
      nps = (st & ~32'h1F) | 32'h10 | 32'(lvl);
      vec = 32'h100 + 32'(lvl) * 32'h40;
    end else begin
      cwe = 1;
      nps = st | 32'h10;
      if (st[4]) begin
        vec = 32'h3C0;
        if (!b) dwe = 1; else ewe = 1;
      end else begin
        ewe = 1;
        vec = st[5] ? 32'h340 : 32'h300;
      end
    end
    if (!b) vec = vec - 32'h100 + base;
    epc_pc = cur_pc;
    if (b) begin
      t = taken_b; pwe = ps_we_b; ew = epc_we_b; sw = eps_we_b; dw = depc_we_b; cw = cause_we_b;
      po = pc_b; so = ps_b; ed = epcd_b; sd = epsd_b; dd = depcd_b; es = epcs_b; ss = epss_b; ca = cause_b;
    end else begin
      t = taken_a; pwe = ps_we_a; ew = epc_we_a; sw = eps_we_a; dw = depc_we_a; cw = cause_we_a;
      po = pc_a; so = ps_a; ed = epcd_a; sd = epsd_a; dd = depcd_a; es = epcs_a; ss = epss_a; ca = cause_a;
    end
    chk(t == take, {tag, " R1 taken"}, 32'(t), 32'(take));
    if (!take) begin
      chk({pwe, ew, sw, dw, cw} == 5'b0, {tag, " R1 strobes idle"}, 32'({pwe, ew, sw, dw, cw}), 0);
    end else begin
      chk(po == vec, {tag, " R8 target pc"}, po, vec);
      chk(pwe && so == nps, {tag, " R7 new status"}, so, nps);
      chk(ew == ewe, {tag, " R6 epc strobe"}, 32'(ew), 32'(ewe));
      if (ewe) begin
        chk(int'(es) == esel, {tag, " R3 epc slot"}, 32'(es), 32'(esel));
        chk(ed == epc_pc, {tag, " R3 epc data"}, ed, epc_pc);
      end
      chk(sw == swe, {tag, " R3 eps strobe"}, 32'(sw), 32'(swe));
      if (swe) begin
        chk(int'(ss) == lvl - 2, {tag, " R3 eps slot"}, 32'(ss), 32'(lvl - 2));
        chk(sd == st, {tag, " R3 eps data"}, sd, st);
      end
      chk(dw == dwe, {tag, " R5 depc strobe"}, 32'(dw), 32'(dwe));
      if (dwe) chk(dd == epc_pc, {tag, " R5 depc data"}, dd, epc_pc);
      chk(cw == cwe, {tag, " R4 cause strobe"}, 32'(cw), 32'(cwe));
      if (cwe) chk(ca == 8'd4, {tag, " R4 cause code"}, 32'(ca), 32'd4);
    end
  endtask

  task automatic run(input string tag, input int lvl, input logic [31:0] st,
                     input logic [31:0] cur_pc, input logic [31:0] base,
                     input logic [7:0] s, input logic [7:0] e);
    dispatch(lvl, st, cur_pc, base, s, e);
    verify(tag, 1'b0, lvl, st, cur_pc, base, s, e);
    verify(tag, 1'b1, lvl, st, cur_pc, base, s, e);
  endtask

  task automatic t_reset();
    chk(!taken_a && !ps_we_a && !epc_we_a && !cause_we_a, "R2 reset quiet",
        32'({taken_a, ps_we_a, epc_we_a, cause_we_a}), 0);
    chk(pc_a == 0, "R2 reset pc", pc_a, 0);
  endtask

  task automatic t_high_levels();
    for (int l = 2; l <= NL; l++)
      run($sformatf("R3 level %0d", l), l, 32'hA0 | 32'(l - 1), 32'h4000 + 32'(l), 32'h8000, 8'hFF, 8'hFF);
  endtask

  task automatic t_level1();
    run("R6 kernel", 1, 32'h0, 32'h1234, 32'h9000, 8'h02, 8'h02);
    run("R6 user", 1, 32'h20, 32'h1238, 32'h9000, 8'h02, 8'h02);
    run("R5 double", 1, 32'h30, 32'h123C, 32'h9000, 8'h02, 8'h02);
  endtask

  task automatic t_reject();
    run("R1 not above", 3, 32'h3, 32'h10, 32'h0, 8'hFF, 8'hFF);
    run("R1 beyond max", NL + 1, 32'h0, 32'h14, 32'h0, 8'hFF, 8'hFF);
    run("R1 disabled", 4, 32'h0, 32'h18, 32'h0, 8'h10, 8'hEF);
    run("R1 other level set", 4, 32'h0, 32'h1C, 32'h0, 8'h08, 8'hFF);
    run("R1 zero level", 0, 32'h0, 32'h20, 32'h0, 8'hFF, 8'hFF);
    @(negedge clk);
    pend = 3'd5; ps = 0; iset = 8'hFF; ien = 8'hFF; check = 1'b0;
    @(negedge clk);
    chk(!taken_a, "R1 no check no take", 32'(taken_a), 0);
  endtask

  task automatic t_pulse();
    run("R2 take", 2, 32'h0, 32'h50, 32'h0, 8'h04, 8'h04);
    @(negedge clk);
    chk(!taken_a && !ps_we_a, "R2 pulse single", 32'(taken_a), 0);
  endtask

  initial begin
    check = 0; pend = 0; ps = 0; pc = 0; vb = 0; iset = 0; ien = 0;
    for (int k = 0; k <= NL; k++) masks[k*NIRQ +: NIRQ] = 8'h1 << k;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_high_levels();
    t_level1();
    t_reject();
    t_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule